// File: doc/BRIEF.md
# ATA Device Task-File Register Interface

This block is the device-side register file of an ATA-style parallel host port. The host reaches it through two chip selects, a 3-bit offset and separate read and write strobes. The command-block select reaches the data port and the seven byte-wide task-file registers. The control-block select reaches alternate status on reads and device control on writes. The block samples both strobes in its own clock domain and acts once per rising strobe edge. It returns read data on a 16-bit bus. It also drives an interrupt request line and a flag that reports when the 16-bit data port is addressed.

On the inner side, a drive controller loads the error, count, address, status and outgoing data registers. It raises interrupts and reads back what the host has programmed. Command and data-port traffic from the host comes out as one-cycle pulses. A strap input tells the block whether it is device 0 or device 1, and the block matches that against the device-select bit written by the host.

Top module: `ata_tf_regs`

## Requirements
- R1: After reset, status reads 0x80 (busy set), the interrupt line is low, and once the controller clears busy, count and sector read 0x01 while error reads 0x01 and cylinder low/high and drive/head read 0x00.
- R2: With only the command select active, offsets map as 1 error (read) / features (write), 2 count, 3 sector, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 status (read) / command (write). These byte registers use data bits 7:0, read back 0 in bits 15:8 and ignore written bits 15:8. With both selects active, a read returns 0 and a write changes nothing.
- R3: With only the control select active, offset 6 reads the status value and writes device control. Other control-select offsets read 0.
- R4: A rising read strobe on status clears the pending interrupt. A read of alternate status leaves it pending.
- R5: The interrupt line is high only when an interrupt is pending, drive/head bit 4 equals the strap (0 = device 0, 1 = device 1), and device-control bit 1 (mask) is 0.
- R6: A rising write strobe on the command offset sets status bit 7 and gives one `cmd_start_o` pulse carrying the byte. A held strobe produces only one pulse.
- R7: Writing device control with bit 2 set sets status bit 7, as does asserting reset.
- R8: While status bit 7 is 1, host writes to offsets 1 to 6 are dropped and reads of offsets 1 to 6 return the status value.
- R9: The data port (offset 0) is 16 bits wide and is active only while status bit 3 is 1. A write then pulses `data_wr_o` with the word, and a read returns the controller-loaded word and pulses `data_rd_o`. When status bit 3 is 0, a read returns 0 and neither pulse occurs.
- R10: `wide_sel_o` is high only while the command select alone is active with offset 0.
- R11: The controller writes error (sel 1) and offsets 2 to 6 (sel 2 to 6), status, the data word and interrupts. `ctl_rdata_o` returns device control at sel 0, features at sel 1, the task-file bytes at sel 2 to 6 and the last command at sel 7. A host command write beats a controller status write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_cmd_i | input | 1 | Command-block chip select |
| cs_ctl_i | input | 1 | Control-block chip select |
| addr_i | input | 3 | Register offset |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, 0 when no read |
| wide_sel_o | output | 1 | 16-bit data port addressed |
| irq_o | output | 1 | Interrupt request |
| strap_dev1_i | input | 1 | 1 when this device is device 1 |
| ctl_tf_we_i | input | 1 | Controller task-file write |
| ctl_tf_sel_i | input | 3 | Controller task-file write select |
| ctl_tf_i | input | 8 | Controller task-file write data |
| ctl_stat_we_i | input | 1 | Controller status write |
| ctl_stat_i | input | 8 | Controller status value |
| ctl_data_we_i | input | 1 | Controller loads outgoing data word |
| ctl_data_i | input | 16 | Outgoing data word |
| ctl_irq_i | input | 1 | Controller raises an interrupt |
| ctl_rsel_i | input | 3 | Controller readback select |
| ctl_rdata_o | output | 8 | Controller readback data |
| cmd_start_o | output | 1 | One-cycle command pulse |
| cmd_o | output | 8 | Last command byte |
| data_wr_o | output | 1 | One-cycle host data write pulse |
| data_wdata_o | output | 16 | Word written by the host |
| data_rd_o | output | 1 | One-cycle host data read pulse |

## Verification
Read data and the wide-port flag are combinational from the offset and the stored registers. The bench samples them shortly after it drives a strobe, before the next clock edge. Every register update, pulse and interrupt change happens on the first clock edge that sees a rising strobe or a controller write. The bench therefore drives inputs on the falling edge and checks state one falling edge later, after exactly one rising edge. It counts output pulses with a clocked monitor, so a held strobe that wrongly repeats a pulse shows up as a miscount.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int ADDR_W = 3;
  localparam int NOFF   = 1 << ADDR_W;
  localparam int REG_W  = 8;
  localparam int DATA_W = 16;
  localparam int NTF    = 6;  // byte registers at offsets 1..6

  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_ERR  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_DH   = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd7;
  localparam logic [ADDR_W-1:0] OFF_ALT  = 3'd6;

  localparam int BUSY_BIT  = 7;
  localparam int XREQ_BIT  = 3;
  localparam int MASK_BIT  = 1;
  localparam int SRST_BIT  = 2;
  localparam int DSEL_BIT  = 4;

  localparam logic [REG_W-1:0] STAT_RST = 8'h80;
  localparam logic [REG_W-1:0] ERR_RST  = 8'h01;

  function automatic logic [REG_W-1:0] tf_rst_val(input int idx);
    return (idx == 2 || idx == 3) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NO = NOFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_cmd_i,
  input  logic          cs_ctl_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output logic          cmd_sel_o,
  output logic          ctl_sel_o,
  output logic [NO-1:0] wr_hit_o,
  output logic          wr_devctl_o,
  output logic          rd_stat_o,
  output logic          rd_data_o,
  output logic          wide_sel_o
);
  logic rd_q, wr_q, rd_rise, wr_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_i;
      wr_q <= wr_i;
    end
  end

  assign rd_rise   = rd_i & ~rd_q;
  assign wr_rise   = wr_i & ~wr_q;
  assign cmd_sel_o = cs_cmd_i & ~cs_ctl_i;
  assign ctl_sel_o = cs_ctl_i & ~cs_cmd_i;

  for (genvar g = 0; g < NO; g++) begin : g_wr
    assign wr_hit_o[g] = wr_rise & cmd_sel_o & (addr_i == AW'(g));
  end

  assign wr_devctl_o = wr_rise & ctl_sel_o & (addr_i == OFF_ALT);
  assign rd_stat_o   = rd_rise & cmd_sel_o & (addr_i == OFF_STAT);
  assign rd_data_o   = rd_rise & cmd_sel_o & (addr_i == OFF_DATA);
  assign wide_sel_o  = cmd_sel_o & (addr_i == OFF_DATA);
endmodule

// File: rtl/ata_tf_store.sv
module ata_tf_store
  import ata_tf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NO = NOFF,
  parameter int RW = REG_W,
  parameter int DW = DATA_W,
  parameter int NT = NTF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NO-1:0]    wr_hit_i,
  input  logic             wr_devctl_i,
  input  logic             rd_data_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ctl_tf_we_i,
  input  logic [AW-1:0]    ctl_tf_sel_i,
  input  logic [RW-1:0]    ctl_tf_i,
  input  logic             ctl_stat_we_i,
  input  logic [RW-1:0]    ctl_stat_i,
  input  logic             ctl_data_we_i,
  input  logic [DW-1:0]    ctl_data_i,
  input  logic [AW-1:0]    ctl_rsel_i,
  output logic [RW-1:0]    ctl_rdata_o,
  output logic [RW-1:0]    err_o,
  output logic [NT*RW-1:0] hregs_o,
  output logic [RW-1:0]    stat_o,
  output logic [RW-1:0]    devctl_o,
  output logic [DW-1:0]    data_o,
  output logic [RW-1:0]    cmd_o,
  output logic             cmd_start_o,
  output logic             data_wr_o,
  output logic [DW-1:0]    data_wdata_o,
  output logic             data_rd_o
);
  logic [RW-1:0] hreg_q [1:NT];
  logic busy, xreq, set_busy;

  assign busy     = stat_o[BUSY_BIT];
  assign xreq     = stat_o[XREQ_BIT];
  assign set_busy = wr_hit_i[OFF_STAT] | (wr_devctl_i & wdata_i[SRST_BIT]);

  // offsets 1..6; controller owns error, so sel 1 never reaches features
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i <= NT; i++) hreg_q[i] <= tf_rst_val(i);
    end else begin
      for (int i = 1; i <= NT; i++) begin
        if (ctl_tf_we_i && i != 1 && ctl_tf_sel_i == AW'(i))
          hreg_q[i] <= ctl_tf_i;
        else if (wr_hit_i[i] && !busy)
          hreg_q[i] <= wdata_i[RW-1:0];
      end
    end
  end

  for (genvar g = 1; g <= NT; g++) begin : g_pack
    assign hregs_o[(g-1)*RW +: RW] = hreg_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o        <= ERR_RST;
      stat_o       <= STAT_RST;
      devctl_o     <= '0;
      data_o       <= '0;
      cmd_o        <= '0;
      cmd_start_o  <= 1'b0;
      data_wr_o    <= 1'b0;
      data_wdata_o <= '0;
      data_rd_o    <= 1'b0;
    end else begin
      if (ctl_tf_we_i && ctl_tf_sel_i == OFF_ERR) err_o <= ctl_tf_i;
      if (ctl_stat_we_i) stat_o <= ctl_stat_i;
      if (set_busy) stat_o[BUSY_BIT] <= 1'b1;
      if (wr_devctl_i) devctl_o <= wdata_i[RW-1:0];
      if (ctl_data_we_i) data_o <= ctl_data_i;
      if (wr_hit_i[OFF_STAT]) cmd_o <= wdata_i[RW-1:0];
      cmd_start_o <= wr_hit_i[OFF_STAT];
      data_wr_o   <= wr_hit_i[OFF_DATA] & xreq;
      data_rd_o   <= rd_data_i & xreq;
      if (wr_hit_i[OFF_DATA] && xreq) data_wdata_o <= wdata_i;
    end
  end

  always_comb begin
    if (ctl_rsel_i == OFF_DATA)      ctl_rdata_o = devctl_o;
    else if (ctl_rsel_i == OFF_STAT) ctl_rdata_o = cmd_o;
    else ctl_rdata_o = hregs_o[(int'(ctl_rsel_i)-1)*RW +: RW];
  end
endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic dev_match_i,
  input  logic mask_i,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign irq_o = pend_q & dev_match_i & ~mask_i;
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = REG_W,
  parameter int DW = DATA_W,
  parameter int NT = NTF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_cmd_i,
  input  logic          cs_ctl_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          wide_sel_o,
  output logic          irq_o,
  input  logic          strap_dev1_i,
  input  logic          ctl_tf_we_i,
  input  logic [AW-1:0] ctl_tf_sel_i,
  input  logic [RW-1:0] ctl_tf_i,
  input  logic          ctl_stat_we_i,
  input  logic [RW-1:0] ctl_stat_i,
  input  logic          ctl_data_we_i,
  input  logic [DW-1:0] ctl_data_i,
  input  logic          ctl_irq_i,
  input  logic [AW-1:0] ctl_rsel_i,
  output logic [RW-1:0] ctl_rdata_o,
  output logic          cmd_start_o,
  output logic [RW-1:0] cmd_o,
  output logic          data_wr_o,
  output logic [DW-1:0] data_wdata_o,
  output logic          data_rd_o
);
  localparam int NO = 1 << AW;

  logic          cmd_sel, ctl_sel, wr_devctl, rd_stat, rd_data;
  logic [NO-1:0] wr_hit;
  logic [RW-1:0] err_w, stat_w, devctl_w, dh_w;
  logic [NT*RW-1:0] tf_w;
  logic [DW-1:0] data_w, rd_word;
  logic          busy, xreq;

  ata_tf_decode #(.AW(AW), .NO(NO)) u_dec (
    .clk_i, .rst_ni, .cs_cmd_i, .cs_ctl_i, .addr_i, .rd_i, .wr_i,
    .cmd_sel_o(cmd_sel), .ctl_sel_o(ctl_sel), .wr_hit_o(wr_hit),
    .wr_devctl_o(wr_devctl), .rd_stat_o(rd_stat), .rd_data_o(rd_data),
    .wide_sel_o
  );

  ata_tf_store #(.AW(AW), .NO(NO), .RW(RW), .DW(DW), .NT(NT)) u_store (
    .clk_i, .rst_ni, .wr_hit_i(wr_hit), .wr_devctl_i(wr_devctl),
    .rd_data_i(rd_data), .wdata_i,
    .ctl_tf_we_i, .ctl_tf_sel_i, .ctl_tf_i, .ctl_stat_we_i, .ctl_stat_i,
    .ctl_data_we_i, .ctl_data_i, .ctl_rsel_i, .ctl_rdata_o,
    .err_o(err_w), .hregs_o(tf_w), .stat_o(stat_w), .devctl_o(devctl_w),
    .data_o(data_w), .cmd_o, .cmd_start_o, .data_wr_o, .data_wdata_o,
    .data_rd_o
  );

  assign dh_w = tf_w[(int'(OFF_DH)-1)*RW +: RW];

  ata_tf_irq u_irq (
    .clk_i, .rst_ni, .set_i(ctl_irq_i), .ack_i(rd_stat),
    .dev_match_i(dh_w[DSEL_BIT] == strap_dev1_i),
    .mask_i(devctl_w[MASK_BIT]), .irq_o
  );

  assign busy = stat_w[BUSY_BIT];
  assign xreq = stat_w[XREQ_BIT];

  // busy shadows offsets 1..6 with status
  always_comb begin
    rd_word = '0;
    if (cmd_sel) begin
      if (addr_i == OFF_DATA)                rd_word = xreq ? data_w : '0;
      else if (addr_i == OFF_STAT || busy)   rd_word = DW'(stat_w);
      else if (addr_i == OFF_ERR)            rd_word = DW'(err_w);
      else rd_word = DW'(tf_w[(int'(addr_i)-1)*RW +: RW]);
    end else if (ctl_sel && addr_i == OFF_ALT) begin
      rd_word = DW'(stat_w);
    end
  end

  assign rdata_o = rd_i ? rd_word : '0;
endmodule

// File: rtl/ata_tf_regs_chk.sv
module ata_tf_regs_chk
  import ata_tf_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_cmd_i,
  input logic          cs_ctl_i,
  input logic [2:0]    addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [15:0]   wdata_i,
  input logic          irq_o,
  input logic          ctl_irq_i,
  input logic          ctl_tf_we_i,
  input logic          cmd_start_o,
  input logic          data_wr_o,
  input logic [7:0]    stat_w,
  input logic [47:0]   tf_w
);
  logic cmd_only, ctl_only;
  assign cmd_only = cs_cmd_i & ~cs_ctl_i;
  assign ctl_only = cs_ctl_i & ~cs_cmd_i;

  assert_stat_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_i) && cmd_only && addr_i == 3'd7 && !ctl_irq_i) |=> !irq_o);

  assert_alt_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_i) && ctl_only && addr_i == 3'd6 && irq_o && !wr_i && !ctl_tf_we_i)
      |=> irq_o);

  assert_mask_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_i) && ctl_only && addr_i == 3'd6 && wdata_i[MASK_BIT]) |=> !irq_o);

  assert_cmd_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_i) && cmd_only && addr_i == 3'd7) |=> (stat_w[BUSY_BIT] && cmd_start_o));

  assert_cmd_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |=> !cmd_start_o);

  assert_srst_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_i) && ctl_only && addr_i == 3'd6 && wdata_i[SRST_BIT]) |=> stat_w[BUSY_BIT]);

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_i) && cmd_only && addr_i != 3'd0 && addr_i != 3'd7 &&
     stat_w[BUSY_BIT] && !ctl_tf_we_i) |=> $stable(tf_w));

  assert_xreq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_i) && cmd_only && addr_i == 3'd0 && !stat_w[XREQ_BIT]) |=> !data_wr_o);
endmodule

bind ata_tf_regs ata_tf_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_cmd_i(cs_cmd_i), .cs_ctl_i(cs_ctl_i),
  .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .irq_o(irq_o),
  .ctl_irq_i(ctl_irq_i), .ctl_tf_we_i(ctl_tf_we_i), .cmd_start_o(cmd_start_o),
  .data_wr_o(data_wr_o), .stat_w(stat_w), .tf_w(tf_w)
);

// File: tb/ata_tf_regs_tb_top.sv
module ata_tf_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_cmd = 0, cs_ctl = 0, rd = 0, wr = 0, strap = 0;
  logic [2:0] addr = '0, tf_sel = '0, rsel = '0;
  logic [15:0] wdata = '0, cdata = '0, rdata, dwdata;
  logic tf_we = 0, st_we = 0, d_we = 0, irq_in = 0;
  logic [7:0] tf_val = '0, st_val = '0, crd, cmd;
  logic wide, irq, cmd_start, dwr, drd;

  int total = 0, bad = 0;
  int cmd_cnt = 0, dwr_cnt = 0, drd_cnt = 0;
  logic [7:0] cmd_last = '0;
  logic [15:0] dwr_last = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_tf_regs dut_i (
    .clk_i(clk), .rst_ni, .cs_cmd_i(cs_cmd), .cs_ctl_i(cs_ctl), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .wide_sel_o(wide),
    .irq_o(irq), .strap_dev1_i(strap), .ctl_tf_we_i(tf_we), .ctl_tf_sel_i(tf_sel),
    .ctl_tf_i(tf_val), .ctl_stat_we_i(st_we), .ctl_stat_i(st_val),
    .ctl_data_we_i(d_we), .ctl_data_i(cdata), .ctl_irq_i(irq_in),
    .ctl_rsel_i(rsel), .ctl_rdata_o(crd), .cmd_start_o(cmd_start), .cmd_o(cmd),
    .data_wr_o(dwr), .data_wdata_o(dwdata), .data_rd_o(drd)
  );

  always @(posedge clk) begin
    if (cmd_start) begin cmd_cnt <= cmd_cnt + 1; cmd_last <= cmd; end
    if (dwr) begin dwr_cnt <= dwr_cnt + 1; dwr_last <= dwdata; end
    if (drd) drd_cnt <= drd_cnt + 1;
  end

  typedef struct packed {
    logic        rd;
    logic [1:0]  sel;   // bit0 command select, bit1 control select
    logic [2:0]  addr;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  tag;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 2'd1, 3'd2, 16'h0005, 16'h0000, 4'd2},  // R2 count
    '{1'b0, 2'd1, 3'd3, 16'h0011, 16'h0000, 4'd2},
    '{1'b0, 2'd1, 3'd4, 16'h0022, 16'h0000, 4'd2},
    '{1'b0, 2'd1, 3'd5, 16'h0033, 16'h0000, 4'd2},
    '{1'b0, 2'd1, 3'd6, 16'hFFA0, 16'h0000, 4'd2},  // R2 upper lane dropped
    '{1'b1, 2'd1, 3'd2, 16'h0000, 16'h0005, 4'd2},
    '{1'b1, 2'd1, 3'd3, 16'h0000, 16'h0011, 4'd2},
    '{1'b1, 2'd1, 3'd4, 16'h0000, 16'h0022, 4'd2},
    '{1'b1, 2'd1, 3'd5, 16'h0000, 16'h0033, 4'd2},
    '{1'b1, 2'd1, 3'd6, 16'h0000, 16'h00A0, 4'd2},
    '{1'b1, 2'd1, 3'd7, 16'h0000, 16'h0040, 4'd2},
    '{1'b1, 2'd2, 3'd6, 16'h0000, 16'h0040, 4'd3},  // R3 alternate status
    '{1'b1, 2'd1, 3'd1, 16'h0000, 16'h0001, 4'd1},  // R1 error reset
    '{1'b0, 2'd1, 3'd1, 16'h0077, 16'h0000, 4'd2},  // features
    '{1'b1, 2'd1, 3'd1, 16'h0000, 16'h0001, 4'd2},
    '{1'b0, 2'd3, 3'd2, 16'h0099, 16'h0000, 4'd2},  // both selects
    '{1'b1, 2'd3, 3'd2, 16'h0000, 16'h0000, 4'd2},
    '{1'b1, 2'd1, 3'd2, 16'h0000, 16'h0005, 4'd2},
    '{1'b1, 2'd2, 3'd3, 16'h0000, 16'h0000, 4'd3},
    '{1'b1, 2'd1, 3'd0, 16'h0000, 16'h0000, 4'd9}   // R9 port closed
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [2:0] a, input logic [15:0] d);
    cs_cmd = sel[0]; cs_ctl = sel[1]; addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0; cs_cmd = 0; cs_ctl = 0;
    @(negedge clk);
  endtask

  task automatic host_rd(input logic [1:0] sel, input logic [2:0] a, output logic [15:0] d);
    cs_cmd = sel[0]; cs_ctl = sel[1]; addr = a; rd = 1;
    #1 d = rdata;
    @(negedge clk); rd = 0; cs_cmd = 0; cs_ctl = 0;
  endtask

  task automatic ctl_stat(input logic [7:0] v);
    st_val = v; st_we = 1; @(negedge clk); st_we = 0;
  endtask

  task automatic ctl_tf(input logic [2:0] s, input logic [7:0] v);
    tf_sel = s; tf_val = v; tf_we = 1; @(negedge clk); tf_we = 0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    host_rd(2'd1, 3'd7, r); chk(r, 16'h0080, "R1 status after reset");
    host_rd(2'd2, 3'd6, r); chk(r, 16'h0080, "R3 alt status after reset");
    chk({15'd0, irq}, 16'd0, "R1 irq low after reset");
    host_rd(2'd1, 3'd2, r); chk(r, 16'h0080, "R8 busy shadows count");
    ctl_stat(8'h40);
    host_rd(2'd1, 3'd2, r); chk(r, 16'h0001, "R1 count reset");
    host_rd(2'd1, 3'd3, r); chk(r, 16'h0001, "R1 sector reset");
    host_rd(2'd1, 3'd4, r); chk(r, 16'h0000, "R1 cyl low reset");
    host_rd(2'd1, 3'd6, r); chk(r, 16'h0000, "R1 drive/head reset");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].rd) begin
        host_rd(VEC[i].sel, VEC[i].addr, r);
        chk(r, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].tag, i));
      end else begin
        host_wr(VEC[i].sel, VEC[i].addr, VEC[i].wd);
      end
    end

    // R11 controller side
    rsel = 3'd1; #1 chk({8'd0, crd}, 16'h0077, "R11 features readback");
    ctl_tf(3'd1, 8'h04);
    host_rd(2'd1, 3'd1, r); chk(r, 16'h0004, "R11 controller error write");
    ctl_tf(3'd2, 8'h10);
    host_rd(2'd1, 3'd2, r); chk(r, 16'h0010, "R11 controller count write");
    rsel = 3'd2; #1 chk({8'd0, crd}, 16'h0010, "R11 count readback");

    // R10 wide port flag
    cs_cmd = 1; addr = 3'd0; #1 chk({15'd0, wide}, 16'd1, "R10 data port flag");
    addr = 3'd1; #1 chk({15'd0, wide}, 16'd0, "R10 flag off other offset");
    cs_cmd = 0; cs_ctl = 1; addr = 3'd0; #1 chk({15'd0, wide}, 16'd0, "R10 flag off control select");
    cs_cmd = 1; #1 chk({15'd0, wide}, 16'd0, "R10 flag off both selects");
    cs_cmd = 0; cs_ctl = 0;
    @(negedge clk);

    // R9 data port
    ctl_stat(8'h48);
    cdata = 16'hBEEF; d_we = 1; @(negedge clk); d_we = 0;
    host_rd(2'd1, 3'd0, r); chk(r, 16'hBEEF, "R9 data read word");
    @(negedge clk);
    chk(16'(drd_cnt), 16'd1, "R9 data read pulse");
    host_wr(2'd1, 3'd0, 16'h1234);
    chk(16'(dwr_cnt), 16'd1, "R9 data write pulse");
    chk(dwr_last, 16'h1234, "R9 data write word");
    ctl_stat(8'h40);
    host_wr(2'd1, 3'd0, 16'h5678);
    chk(16'(dwr_cnt), 16'd1, "R9 write ignored when closed");
    host_rd(2'd1, 3'd0, r); chk(r, 16'h0000, "R9 read zero when closed");
    @(negedge clk);
    chk(16'(drd_cnt), 16'd1, "R9 no read pulse when closed");

    // R4 / R5 interrupt
    irq_in = 1; @(negedge clk); irq_in = 0;
    chk({15'd0, irq}, 16'd1, "R5 irq raised");
    host_rd(2'd2, 3'd6, r); chk(r, 16'h0040, "R3 alt status value");
    chk({15'd0, irq}, 16'd1, "R4 alt read keeps irq");
    host_wr(2'd1, 3'd6, 16'h00B0);
    chk({15'd0, irq}, 16'd0, "R5 other device selected");
    strap = 1; #1 chk({15'd0, irq}, 16'd1, "R5 strap matches device 1");
    strap = 0;
    host_wr(2'd1, 3'd6, 16'h00A0);
    chk({15'd0, irq}, 16'd1, "R5 device 0 reselected");
    host_wr(2'd2, 3'd6, 16'h0002);
    chk({15'd0, irq}, 16'd0, "R5 mask bit blocks");
    host_wr(2'd2, 3'd6, 16'h0000);
    chk({15'd0, irq}, 16'd1, "R5 mask cleared");
    host_rd(2'd1, 3'd7, r); chk(r, 16'h0040, "R4 status value");
    chk({15'd0, irq}, 16'd0, "R4 status read clears irq");

    // R6 command with held strobe
    cs_cmd = 1; addr = 3'd7; wdata = 16'h0020; wr = 1;
    repeat (3) @(negedge clk);
    wr = 0; cs_cmd = 0;
    @(negedge clk);
    chk(16'(cmd_cnt), 16'd1, "R6 single command pulse");
    chk({8'd0, cmd_last}, 16'h0020, "R6 command byte");
    host_rd(2'd1, 3'd7, r); chk(r, 16'h00C0, "R6 busy set by command");

    // R8 busy blocks writes
    host_wr(2'd1, 3'd2, 16'h0055);
    host_rd(2'd1, 3'd2, r); chk(r, 16'h00C0, "R8 read shadows status");
    ctl_stat(8'h40);
    host_rd(2'd1, 3'd2, r); chk(r, 16'h0010, "R8 write while busy dropped");

    // R7 soft reset bit
    host_wr(2'd2, 3'd6, 16'h0004);
    host_rd(2'd2, 3'd6, r); chk(r, 16'h00C0, "R7 soft reset sets busy");
    host_wr(2'd2, 3'd6, 16'h0000);
    ctl_stat(8'h40);

    // R11 priority: command write beats controller status write
    st_val = 8'h00; st_we = 1;
    cs_cmd = 1; addr = 3'd7; wdata = 16'h0091; wr = 1;
    @(negedge clk);
    st_we = 0; wr = 0; cs_cmd = 0;
    @(negedge clk);
    host_rd(2'd1, 3'd7, r); chk(r, 16'h0080, "R11 command beats status write");
    chk(16'(cmd_cnt), 16'd2, "R6 second command pulse");
    rsel = 3'd7; #1 chk({8'd0, crd}, 16'h0091, "R11 command readback");

    // R7 reset sets busy and drops pending irq
    irq_in = 1; @(negedge clk); irq_in = 0;
    chk({15'd0, irq}, 16'd1, "R5 irq before reset");
    rst_ni = 0; @(negedge clk); rst_ni = 1; @(negedge clk);
    host_rd(2'd1, 3'd7, r); chk(r, 16'h0080, "R7 reset sets busy");
    chk({15'd0, irq}, 16'd0, "R1 irq cleared by reset");

    done = 1;
    summary();
    $finish;
  end
endmodule